// File: doc/BRIEF.md
# Watchdog Timer With Selectable Expiry Event

This block is a watchdog timer driven by the system clock. Software programs a reload value and then enables the timer. From then on it counts down by one each cycle and has to be serviced before the count runs out. Any write to the status location services it. If the count reaches zero first, the block raises one expiry event, chosen by software: a one-cycle reset request, a non-maskable interrupt, or a general-purpose interrupt. A halt input freezes the count while a debugger has stopped the system.

Software sees three word locations on a simple register port. The write side is a strobe. The read side is combinational on the address.
- Address 0 is the 16-bit control word. Bits [1:0] select the event, bits [11:4] hold the enable code, and bit 15 is the expiry flag.
- Address 1 holds the reload value.
- Address 2 returns the live count.

Only the code 0xAD in the enable field switches the timer off. Every other code keeps it running. The expiry flag can be cleared only by a write that also leaves the timer disabled.

Top module: `wdog_top`

## Requirements
- R1: After reset the control word reads 0x0AD0 (enable code 0xAD, event select 00, flag 0), the live count reads 0, and evtReset, evtNmi, evtIrq and resetSrc are all low.
- R2: A control write whose enable field is not 0xAD, made while the timer is disabled, loads the live count from the reload value (address 1). Address 2 reads back the live count.
- R3: While the timer is enabled and not halted, the live count drops by one on every clock edge. It holds at zero and never wraps.
- R4: A write of any data to address 2 reloads the live count from the reload value.
- R5: While haltIn is high the live count does not change, unless a reload happens.
- R6: A control write with enable field 0xAD disables the timer and freezes the live count. Any other enable code leaves the timer running.
- R7: With event select 00 (reset), the edge that takes the count from 1 to 0 drives evtReset high for exactly one cycle. The same edge sets resetSrc, which then stays high until rstN. Bit 15 of the control word reads 0 afterwards.
- R8: With event select 01 (NMI), expiry sets bit 15, and evtNmi is high while bit 15 is set. evtIrq and evtReset stay low.
- R9: With event select 10 or 11 (general interrupt), expiry sets bit 15, and evtIrq is high while bit 15 is set.
- R10: Writing 1 to bit 15 clears the flag only if the same write puts 0xAD in the enable field. With any other enable code the flag stays set.
- R11: A reload value of zero never produces an expiry event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 reload, 2 live count) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| haltIn | input | 1 | Debug halt; freezes counting |
| evtReset | output | 1 | One-cycle reset request on expiry |
| evtNmi | output | 1 | Non-maskable interrupt level |
| evtIrq | output | 1 | General-purpose interrupt level |
| resetSrc | output | 1 | Sticky flag: a watchdog reset was requested |

## Verification
The assertions assume that a write which disables the timer or clears the flag never lands on the same edge as an expiry. In that case the set of the flag would win over the clear. The assertions also treat every write as a possible reload, so they only claim a frozen or zero count on cycles with no register write. The stimulus keeps to this by separating each clearing write from an expiry by at least one idle cycle. It also keeps regWrEn low across every window in which it checks that the count is frozen or held at zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    EV_RESET = 2'b00,
    EV_NMI   = 2'b01,
    EV_GPI_A = 2'b10,
    EV_GPI_B = 2'b11
  } evtSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // copy reload value into live count
    logic dec;    // count down one step (if nonzero)
  } wdStrobe_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_LIVE   = 2'd2;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [7:0] DIS_CODE = 8'hAD
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrCtrl,
  input  logic        wrLive,
  input  logic [15:0] wrData,
  input  logic        haltIn,
  input  logic        expireNow,
  output wdStrobe_t   strobe,
  output logic [15:0] ctrlWord,
  output logic        evtReset,
  output logic        evtNmi,
  output logic        evtIrq,
  output logic        resetSrc
);

  logic [7:0] enField;
  evtSel_t    evtSel;
  logic       expFlag;
  logic       rstPulse;
  logic       srcFlag;

  logic       running;
  logic [7:0] newEn;
  logic       enableEdge;
  logic       clearReq;
  logic       rstExpire;

  assign running    = (enField != DIS_CODE);
  assign newEn      = wrData[11:4];
  assign enableEdge = wrCtrl && !running && (newEn != DIS_CODE);
  assign clearReq   = wrCtrl && wrData[15] && (newEn == DIS_CODE);
  assign rstExpire  = expireNow && (evtSel == EV_RESET);

  always_comb begin
    strobe.load = wrLive || enableEdge;
    strobe.dec  = running && !haltIn && !strobe.load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enField  <= DIS_CODE;
      evtSel   <= EV_RESET;
      expFlag  <= 1'b0;
      rstPulse <= 1'b0;
      srcFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enField <= newEn;
        evtSel  <= evtSel_t'(wrData[1:0]);
      end
      if (expireNow) expFlag <= !rstExpire;
      else if (clearReq) expFlag <= 1'b0;
      rstPulse <= rstExpire;
      srcFlag  <= srcFlag || rstExpire;
    end
  end

  assign ctrlWord = {expFlag, 3'b000, enField, 2'b00, evtSel};
  assign evtReset = rstPulse;
  assign evtNmi   = expFlag && (evtSel == EV_NMI);
  assign evtIrq   = expFlag && evtSel[1];
  assign resetSrc = srcFlag;

endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReload,
  input  logic [CNT_W-1:0] wrData,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] reloadVal,
  output logic             expireNow
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic nonZero;

  assign nonZero   = (liveCnt != '0);
  assign expireNow = strobe.dec && (liveCnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= RELOAD_RST;
      liveCnt   <= '0;
    end else begin
      if (wrReload) reloadVal <= wrData;
      if (strobe.load) liveCnt <= reloadVal;
      else if (strobe.dec && nonZero) liveCnt <= liveCnt - ONE;
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned      CNT_W      = 32,
  parameter logic [7:0]       DIS_CODE   = 8'hAD,
  parameter logic [CNT_W-1:0] RELOAD_RST = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        haltIn,
  output logic        evtReset,
  output logic        evtNmi,
  output logic        evtIrq,
  output logic        resetSrc
);

  wdStrobe_t        strobe;
  logic [15:0]      ctrlWord;
  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] reloadVal;
  logic             expireNow;
  logic             wrCtrl, wrReload, wrLive;

  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrReload = regWrEn && (regAddr == ADDR_RELOAD);
  assign wrLive   = regWrEn && (regAddr == ADDR_LIVE);

  wdog_ctrl #(.DIS_CODE(DIS_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrLive(wrLive),
    .wrData(regWrData[15:0]), .haltIn(haltIn), .expireNow(expireNow),
    .strobe(strobe), .ctrlWord(ctrlWord), .evtReset(evtReset),
    .evtNmi(evtNmi), .evtIrq(evtIrq), .resetSrc(resetSrc)
  );

  wdog_dp #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_dp (
    .clk(clk), .rstN(rstN), .wrReload(wrReload),
    .wrData(regWrData[CNT_W-1:0]), .strobe(strobe),
    .liveCnt(liveCnt), .reloadVal(reloadVal), .expireNow(expireNow)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:   regRdData = {16'h0000, ctrlWord};
      ADDR_RELOAD: regRdData = 32'(reloadVal);
      ADDR_LIVE:   regRdData = 32'(liveCnt);
      default:     regRdData = 32'h0;
    endcase
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             haltIn,
  input logic [CNT_W-1:0] liveCnt,
  input logic             ctrlFlag,
  input logic             evtReset,
  input logic             evtNmi,
  input logic             evtIrq,
  input logic             resetSrc
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evtReset |=> !evtReset);

  a_r7_src_sticky: assert property (@(posedge clk) disable iff (!rstN)
    resetSrc |=> resetSrc);

  a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (haltIn && !regWrEn) |=> $stable(liveCnt));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == '0 && !regWrEn) |=> (liveCnt == '0));

  a_r8_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtReset, evtNmi, evtIrq}));

  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlFlag && !regWrEn) |=> ctrlFlag);

  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtReset) |-> (liveCnt == '0));

endmodule

bind wdog_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .haltIn(haltIn),
  .liveCnt(liveCnt), .ctrlFlag(ctrlWord[15]), .evtReset(evtReset),
  .evtNmi(evtNmi), .evtIrq(evtIrq), .resetSrc(resetSrc)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        haltIn = 1'b0;
  logic        evtReset, evtNmi, evtIrq, resetSrc;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  wdog_top u_wdog_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .haltIn(haltIn),
    .evtReset(evtReset), .evtNmi(evtNmi), .evtIrq(evtIrq), .resetSrc(resetSrc)
  );

  // {reload, cycles waited after enable}
  localparam int NVEC = 6;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd100,        32'd0},
    {32'd10,         32'd3},
    {32'd5,          32'd5},
    {32'd1,          32'd4},
    {32'd0,          32'd3},
    {32'hFFFF_FFFF,  32'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0AD0);
    rd(2'd2, v); check("R1 live", v, 32'h0);
    check("R1 events", {28'h0, evtReset, evtNmi, evtIrq, resetSrc}, 32'h0);

    // R2 R3 R9 R11 vector walk, general interrupt mode
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] rl, wt, expCnt, expIrq;
      rl = VEC[i][63:32];
      wt = VEC[i][31:0];
      expCnt = (wt >= rl) ? 32'h0 : rl - wt;
      expIrq = (rl != 0 && wt >= rl) ? 32'h1 : 32'h0;
      wr(2'd0, 32'h8AD2);          // disable and clear flag
      wr(2'd1, rl);
      wr(2'd0, 32'h0002);          // enable, event select 10
      repeat (wt) @(negedge clk);
      rd(2'd2, v);
      check("R2/R3 live count", v, expCnt);
      check("R9/R11 irq", {31'h0, evtIrq}, expIrq);
    end

    // R4 any write to live location reloads
    wr(2'd0, 32'h8AD2);
    wr(2'd1, 32'd20);
    wr(2'd0, 32'h0002);
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R3 count down", v, 32'd15);
    wr(2'd2, 32'h1234);
    rd(2'd2, v); check("R4 reload", v, 32'd20);

    // R5 halt freezes
    haltIn = 1'b1;
    rd(2'd2, held);
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R5 halt", v, held);
    haltIn = 1'b0;
    @(negedge clk);
    rd(2'd2, v); check("R5 resume", v, held - 1);

    // R6 non-disable code keeps running, 0xAD stops
    wr(2'd0, 32'h0552);
    rd(2'd2, held);
    @(negedge clk);
    rd(2'd2, v); check("R6 other code runs", v, held - 1);
    wr(2'd0, 32'h0AD2);
    rd(2'd2, held);
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R6 disabled frozen", v, held);

    // R7 reset event
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h0000);
    repeat (3) @(negedge clk);
    check("R7 pulse", {31'h0, evtReset}, 32'h1);
    check("R7 src", {31'h0, resetSrc}, 32'h1);
    rd(2'd0, v); check("R7 flag clear", {31'h0, v[15]}, 32'h0);
    @(negedge clk);
    check("R7 pulse one cycle", {31'h0, evtReset}, 32'h0);
    check("R7 src sticky", {31'h0, resetSrc}, 32'h1);

    // R8 NMI event, R10 clear rules
    wr(2'd0, 32'h0AD0);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h0001);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R8 flag set", {31'h0, v[15]}, 32'h1);
    check("R8 nmi/irq", {30'h0, evtNmi, evtIrq}, 32'h2);
    @(negedge clk);
    wr(2'd0, 32'h8001);            // clear attempt while enabled
    rd(2'd0, v); check("R10 no clear enabled", {31'h0, v[15]}, 32'h1);
    check("R10 nmi held", {31'h0, evtNmi}, 32'h1);
    wr(2'd0, 32'h8AD1);            // clear with disable
    rd(2'd0, v); check("R10 cleared", {31'h0, v[15]}, 32'h0);
    check("R10 nmi dropped", {31'h0, evtNmi}, 32'h0);

    summary();
  end

endmodule